// File: doc/BRIEF.md
# Radix-4 Shared-Multiplicand Montgomery Multiplier

This unit forms two Montgomery products at once, and both use the same multiplicand P. With K-bit operands and H = K/2 radix-4 digits, it returns X congruent to R·P·4^-H and Y congruent to P·P·4^-H modulo an odd modulus n. Exponentiation ladders use this pairing because a squaring and a multiplication share one operand. The caller supplies 2n and 3n along with n, so every reduction step is a single addition.

One reduction datapath produces the stream T[i] = P·4^-i mod n. At each step it picks a 2-bit quotient and adds 0, n, 2n or 3n, so that the two low bits of the sum become zero. It then shifts the sum right by two. The two bits that enter the top of each word are formed by a small 2-bit adder fed by the next word's low bits and the carry out of the current word.

Two accumulators run one step behind the reduction. They take the digits of R and P from most significant to least significant and add a digit-selected pair of operands drawn from T and 2T. Each uses a carry-save stage followed by a word-sliced adder. The accumulators do not reduce their contents, so X and Y are correct residues that can be several multiples of n above the fully reduced value.

Top module: `cmm_r4_top`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `x_out` and `y_out` are zero.
- R2: When the unit is idle and `start` is sampled high on a rising edge, that edge captures `p_in`, `r_in`, `n_in`, `n2_in` and `n3_in`, and clears both accumulators to zero.
- R3: For an odd modulus, the quotient q in 0..3 is chosen so that the two low bits of T + q·n are zero. The operand added is 0, n, 2n or 3n for q = 0, 1, 2 and 3, and this works for moduli congruent to both 1 and 3 modulo 4.
- R4: Each reduction step replaces T by (T + q·n)/4. Starting from T = P with P < n, T stays below n.
- R5: For each 2-bit digit d, the accumulator adds the operand pair (0,0) for d=0, (0,T) for d=1, (T,T) for d=2 and (T,2T) for d=3. 2T is built per word with the top bit of the lower word shifted in. Digits are taken from bit pair K-1:K-2 down to 1:0.
- R6: When done, `x_out` mod n equals R·P·4^-H mod n and `y_out` mod n equals P·P·4^-H mod n, with H = K/2. Both outputs are below 3·H·n.
- R7: `done` is a one-cycle pulse on the (H+1)-th rising edge after the edge that accepted `start`.
- R8: A `start` that arrives while a computation is running is ignored. It produces no extra `done` and does not change the running result.
- R9: Between `done` and the next accepted `start`, `x_out` and `y_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle |
| p_in | input | K | Shared multiplicand P (must be below n) |
| r_in | input | K | Second multiplier R |
| n_in | input | K | Odd modulus n |
| n2_in | input | K+2 | Precomputed 2n |
| n3_in | input | K+2 | Precomputed 3n |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | XO | Unreduced residue of R·P·4^-H |
| y_out | output | XO | Unreduced residue of P·P·4^-H |

## Verification
The edge that accepts `start` clears both accumulators, so the bench samples zero at the first falling edge after launch. Both results and `done` are due on the (H+1)-th rising edge after that accepting edge. The driver records the cycle count when it raises `start`, and the monitor checks that the falling edge at which it sees `done` lies exactly H+2 counts later, because the accepting edge is counted as well. At that falling edge the monitor compares both outputs modulo n against a reference computed by halving modulo n, and checks the bound 3·H·n. The results must then stay unchanged until the next accepted `start`.

// File: rtl/cmm_pkg.sv
`timescale 1ns/1ps
package cmm_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} cmm_state_e;

  // quotient that clears the two low bits of t + q*n for odd n
  // (n mod 4 is its own inverse mod 4, so q = -t*n mod 4)
  function automatic logic [1:0] pick_q(logic [1:0] t_lo, logic [1:0] n_lo);
    logic [3:0] pr;
    pr = {2'b00, t_lo} * {2'b00, n_lo};
    return 2'b00 - pr[1:0];
  endfunction
endpackage

// File: rtl/cmm_qsel.sv
`timescale 1ns/1ps
module cmm_qsel #(
  parameter int K = 32
) (
  input  logic [1:0]   t_lo,
  input  logic [K-1:0] n_v,
  input  logic [K+1:0] n2_v,
  input  logic [K+1:0] n3_v,
  output logic [K+1:0] pp
);
  import cmm_pkg::*;
  logic [1:0] q;

  assign q = pick_q(t_lo, n_v[1:0]);

  always_comb begin
    case (q)
      2'd0:    pp = '0;
      2'd1:    pp = {2'b00, n_v};
      2'd2:    pp = n2_v;
      default: pp = n3_v;
    endcase
  end
endmodule

// File: rtl/cmm_reduce.sv
`timescale 1ns/1ps
module cmm_reduce #(
  parameter int W  = 16,
  parameter int NW = 2,
  localparam int K = W * NW
) (
  input  logic [K-1:0] t_cur,
  input  logic [K+1:0] pp,
  output logic [K-1:0] t_nxt,
  output logic [1:0]   sum_lo
);
  logic         cy [NW+1];
  logic [W-1:0] sw [NW];

  assign cy[0] = 1'b0;

  for (genvar j = 0; j < NW; j++) begin : g_word
    logic [1:0] early;
    // word adder with carry-in from the word below
    assign {cy[j+1], sw[j]} = {1'b0, t_cur[j*W +: W]} + {1'b0, pp[j*W +: W]}
                            + {{W{1'b0}}, cy[j]};
    // two bits that move into the top of this word after the shift,
    // formed by a 2-bit add instead of waiting for the upper word's sum
    if (j < NW-1) begin : g_mid
      assign early = t_cur[(j+1)*W +: 2] + pp[(j+1)*W +: 2] + {1'b0, cy[j+1]};
    end else begin : g_top
      assign early = pp[K +: 2] + {1'b0, cy[j+1]};
    end
    assign t_nxt[j*W +: W] = {early, sw[j][W-1:2]};
  end

  assign sum_lo = sw[0][1:0];
endmodule

// File: rtl/cmm_accum.sv
`timescale 1ns/1ps
module cmm_accum #(
  parameter int W   = 16,
  parameter int XNW = 3,
  parameter int K   = 32,
  localparam int XWP = W * XNW
) (
  input  logic [XWP-1:0] acc,
  input  logic [K-1:0]   tv,
  input  logic [1:0]     dig,
  output logic [XWP-1:0] acc_nxt
);
  logic [XWP-2:0] te;
  logic [XWP-1:0] tf, t2, opa, opb, sv, cs;
  logic [XWP-2:0] cv;
  logic           co [XNW];

  assign te    = {{(XWP-1-K){1'b0}}, tv};
  assign tf    = {1'b0, te};
  assign co[0] = 1'b0;

  always_comb begin
    case (dig)
      2'd0:    begin opa = '0; opb = '0; end
      2'd1:    begin opa = '0; opb = tf; end
      2'd2:    begin opa = tf; opb = tf; end
      default: begin opa = tf; opb = t2; end
    endcase
  end

  assign sv = acc ^ opa ^ opb;

  for (genvar j = 0; j < XNW; j++) begin : g_word
    // doubled T and the shifted carry both pull one bit from the word below
    if (j == 0) begin : g_lo
      assign t2[W-1:0] = {te[W-2:0], 1'b0};
      assign cs[W-1:0] = {cv[W-2:0], 1'b0};
    end else begin : g_up
      assign t2[j*W +: W] = {te[j*W +: W-1], te[j*W-1]};
      assign cs[j*W +: W] = {cv[j*W +: W-1], cv[j*W-1]};
    end

    if (j < XNW-1) begin : g_body
      assign cv[j*W +: W] = (acc[j*W +: W] & opa[j*W +: W])
                          | (acc[j*W +: W] & opb[j*W +: W])
                          | (opa[j*W +: W] & opb[j*W +: W]);
      assign {co[j+1], acc_nxt[j*W +: W]} = {1'b0, sv[j*W +: W]} + {1'b0, cs[j*W +: W]}
                                          + {{W{1'b0}}, co[j]};
    end else begin : g_last
      assign cv[j*W +: W-1] = (acc[j*W +: W-1] & opa[j*W +: W-1])
                            | (acc[j*W +: W-1] & opb[j*W +: W-1])
                            | (opa[j*W +: W-1] & opb[j*W +: W-1]);
      assign acc_nxt[j*W +: W] = sv[j*W +: W] + cs[j*W +: W] + {{(W-1){1'b0}}, co[j]};
    end
  end
endmodule

// File: rtl/cmm_r4_top.sv
`timescale 1ns/1ps
module cmm_r4_top #(
  parameter int W  = 16,
  parameter int NW = 2,
  localparam int K  = W * NW,
  localparam int H  = K / 2,
  localparam int XO = ((K + $clog2(3 * H) + 1 + W - 1) / W) * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [K-1:0]  p_in,
  input  logic [K-1:0]  r_in,
  input  logic [K-1:0]  n_in,
  input  logic [K+1:0]  n2_in,
  input  logic [K+1:0]  n3_in,
  output logic          done,
  output logic [XO-1:0] x_out,
  output logic [XO-1:0] y_out
);
  import cmm_pkg::*;

  localparam int XNW = XO / W;
  localparam int CW  = $clog2(H + 1);

  cmm_state_e    st_q;
  logic          busy;
  logic [CW-1:0] cnt_q;
  logic [K-1:0]  t_q, n_q, rd_q, pd_q;
  logic [K+1:0]  n2_q, n3_q;
  logic [XO-1:0] xa_q, ya_q, xa_n, ya_n;
  logic          done_q;
  logic [K+1:0]  pp;
  logic [K-1:0]  t_nxt;
  logic [1:0]    red_lo;

  assign busy  = (st_q == ST_RUN);
  assign done  = done_q;
  assign x_out = xa_q;
  assign y_out = ya_q;

  cmm_qsel #(.K(K)) u_qsel (
    .t_lo (t_q[1:0]),
    .n_v  (n_q),
    .n2_v (n2_q),
    .n3_v (n3_q),
    .pp   (pp)
  );

  cmm_reduce #(.W(W), .NW(NW)) u_red (
    .t_cur  (t_q),
    .pp     (pp),
    .t_nxt  (t_nxt),
    .sum_lo (red_lo)
  );

  cmm_accum #(.W(W), .XNW(XNW), .K(K)) u_acc_x (
    .acc     (xa_q),
    .tv      (t_q),
    .dig     (rd_q[K-1:K-2]),
    .acc_nxt (xa_n)
  );

  cmm_accum #(.W(W), .XNW(XNW), .K(K)) u_acc_y (
    .acc     (ya_q),
    .tv      (t_q),
    .dig     (pd_q[K-1:K-2]),
    .acc_nxt (ya_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      t_q    <= '0;
      n_q    <= '0;
      n2_q   <= '0;
      n3_q   <= '0;
      rd_q   <= '0;
      pd_q   <= '0;
      xa_q   <= '0;
      ya_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            t_q   <= p_in;
            pd_q  <= p_in;
            rd_q  <= r_in;
            n_q   <= n_in;
            n2_q  <= n2_in;
            n3_q  <= n3_in;
            xa_q  <= '0;
            ya_q  <= '0;
            cnt_q <= '0;
            st_q  <= ST_RUN;
          end
        end
        default: begin
          // reduction leads; accumulation trails by one step
          if (cnt_q != CW'(H)) t_q <= t_nxt;
          if (cnt_q != '0) begin
            xa_q <= xa_n;
            ya_q <= ya_n;
            rd_q <= {rd_q[K-3:0], 2'b00};
            pd_q <= {pd_q[K-3:0], 2'b00};
          end
          if (cnt_q == CW'(H)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cmm_r4_chk.sv
`timescale 1ns/1ps
module cmm_r4_chk #(
  parameter int K  = 32,
  parameter int XO = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          busy,
  input logic [K-1:0]  t_cur,
  input logic [K-1:0]  n_cur,
  input logic [1:0]    sum_lo,
  input logic [XO-1:0] x_out,
  input logic [XO-1:0] y_out
);
  a_r3_low_bits_cleared: assert property (@(posedge clk) disable iff (rst)
    busy |-> sum_lo == 2'b00);

  a_r4_stream_below_modulus: assert property (@(posedge clk) disable iff (rst)
    busy |-> t_cur < n_cur);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_at_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));
endmodule

bind cmm_r4_top cmm_r4_chk #(.K(K), .XO(XO)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .busy   (busy),
  .t_cur  (t_q),
  .n_cur  (n_q),
  .sum_lo (red_lo),
  .x_out  (x_out),
  .y_out  (y_out)
);

// File: tb/test_cmm_r4_top.sv
`timescale 1ns/1ps
module test_cmm_r4_top;
  localparam int W  = 16;
  localparam int NW = 2;
  localparam int K  = W * NW;
  localparam int H  = K / 2;
  localparam int XO = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [K-1:0]  p = '0, r = '0, n = 32'd1;
  logic [K+1:0]  n2 = '0, n3 = '0;
  logic          done;
  logic [XO-1:0] x, y;

  int total = 0, bad = 0, pushes = 0, dones = 0;
  longint unsigned cyc = 0;
  longint unsigned qx[$], qy[$], qn[$], qc[$];
  string qt[$];
  longint unsigned last_x = 0, last_y = 0;
  longint unsigned ex, ey, nn, c0;
  string tg;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmm_r4_top #(.W(W), .NW(NW)) i_cmm_r4_top (
    .clk(clk), .rst(rst), .start(start),
    .p_in(p), .r_in(r), .n_in(n), .n2_in(n2), .n3_in(n3),
    .done(done), .x_out(x), .y_out(y)
  );

  task automatic check(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference: reduce the plain product, then halve modulo m 2H times
  function automatic longint unsigned ref_mont(longint unsigned a, longint unsigned b,
                                               longint unsigned m);
    longint unsigned v;
    v = (a * b) % m;
    for (int i = 0; i < 2 * H; i++) v = v[0] ? (v + m) >> 1 : v >> 1;
    return v;
  endfunction

  task automatic launch(input logic [K-1:0] pv, input logic [K-1:0] rv,
                        input logic [K-1:0] nv, input string tag);
    while (qx.size() != 0) @(negedge clk);
    @(negedge clk);
    p = pv; r = rv; n = nv;
    n2 = {1'b0, nv, 1'b0};
    n3 = {2'b00, nv} + {1'b0, nv, 1'b0};
    qx.push_back(ref_mont(rv, pv, nv));
    qy.push_back(ref_mont(pv, pv, nv));
    qn.push_back(nv);
    qc.push_back(cyc);
    qt.push_back(tag);
    pushes++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(x == 0 && y == 0, {"R2 accumulators cleared / ", tag}, x | y, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      dones++;
      if (qx.size() == 0) begin
        check(1'b0, "R8 done without an accepted start", 1, 0);
      end else begin
        ex = qx.pop_front(); ey = qy.pop_front();
        nn = qn.pop_front(); c0 = qc.pop_front(); tg = qt.pop_front();
        check((x % nn) == ex, {"R6 X residue / ", tg}, x % nn, ex);
        check((y % nn) == ey, {"R6 Y residue / ", tg}, y % nn, ey);
        check(x < 3 * H * nn, {"R6 X bound / ", tg}, x, 3 * H * nn);
        check(y < 3 * H * nn, {"R6 Y bound / ", tg}, y, 3 * H * nn);
        check(cyc - c0 == H + 2, {"R7 latency / ", tg}, cyc - c0, H + 2);
        last_x = x;
        last_y = y;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 200000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [31:0] nv;
    s = 32'h2468_ace1;
    repeat (3) @(negedge clk);
    check(done == 0 && x == 0 && y == 0, "R1 reset state", x | y | done, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && x == 0 && y == 0, "R1 after reset release", x | y | done, 0);

    launch(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 digit 3 (T,2T), R3 n%4=3");
    launch(32'd2, 32'd5, 32'd3, "R4 tiny modulus");
    launch(32'h1234_5678, 32'h0, 32'h8000_0001, "R5 digit 0, R3 n%4=1");
    launch(32'h0, 32'hDEAD_BEEF, 32'hC000_0005, "R4 P zero");
    launch(32'h7654_3210, 32'h5555_5555, 32'hF123_4567, "R5 digit 1 (0,T)");
    launch(32'h0BAD_F00D, 32'hAAAA_AAAA, 32'hE000_0003, "R5 digit 2 (T,T)");
    launch(32'h8000_0000, 32'h8000_0000, 32'h8000_0001, "R4 P=n-1");
    for (int i = 0; i < 12; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      nv = s | 32'h1 | ((i % 2 == 0) ? 32'h8000_0000 : 32'h0);
      s = s * 32'd1103515245 + 32'd12345;
      launch(s % nv, s ^ 32'h5a5a_1234, nv, (i % 2 == 0) ? "R3 random odd n" : "R6 random");
    end
    while (qx.size() != 0) @(negedge clk);

    // R9: outputs stay after done while idle
    repeat (10) @(negedge clk);
    check(x == last_x, "R9 X held while idle", x, last_x);
    check(y == last_y, "R9 Y held while idle", y, last_y);

    // R8: a second start during a run is ignored
    launch(32'h0001_2345, 32'h9876_5432, 32'hFFF1_0001, "R8 first operand set kept");
    repeat (3) @(negedge clk);
    p = 32'h1111_1111; r = 32'h2222_2222; n = 32'h7777_7777;
    n2 = {1'b0, n, 1'b0}; n3 = {2'b00, n} + {1'b0, n, 1'b0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (qx.size() != 0) @(negedge clk);
    repeat (H + 8) @(negedge clk);
    check(dones == pushes, "R8 no extra done for ignored start", dones, pushes);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule